// File: doc/BRIEF.md
# CRC-4 Multiframe Alignment Tracker

This block finds and follows the 16-frame CRC-4 multiframe of a 2048 kbit/s primary-rate stream. Basic frame alignment is assumed to be in place already. Each frame, a strobe arrives together with a flag that marks frames carrying the frame alignment signal and the first bit of timeslot 0. The tracker looks for the six-bit multiframe alignment word and confirms it once before declaring lock. It then reports the number of the current frame within the multiframe.

Once locked, the tracker emits a single-cycle pulse when lock is gained and a single-cycle pulse at the start of every multiframe. Lock can be dropped in two ways. One is repeated missing alignment words, if that check is enabled. The other is a CRC-4 error count that reaches its limit inside a fixed window of submultiframes, if that check is enabled. The CRC-4 checksum itself is computed elsewhere and arrives here as a per-frame error flag. The word search can rely on the primary frame phase, accepting a word only when it ends on a frame flagged as non-FAS. It can also run on its own and ignore that flag.

Top module: `mfa_tracker`

## Requirements
- R1: While `mf_en` is 0 the tracker is idle: `mf_in_sync` is 0, `frame_num` is 0, no pulse is raised and the bit history is cleared. One cycle after `mf_en` returns to 1 the search begins.
- R2: The alignment word is the first timeslot-0 bit of frames 1, 3, 5, 7, 9 and 11, with the values 0, 0, 1, 0, 1, 1 in that frame order. It is recognised on the strobe of the frame that carries its last bit.
- R3: With `reuse_bfa` = 1 a word counts only if `frm_is_fas` is 0 on the strobe of its last bit. With `reuse_bfa` = 0 the flag is ignored.
- R4: In hunt, a recognised word sets `frame_num` to 11 after that strobe and starts verification. In-sync is declared only if the word is recognised again exactly 16 frames later. Otherwise the search returns to hunt.
- R5: Outside idle, `frame_num` advances by one per strobe and wraps from 15 to 0. While in sync it therefore equals the number of the last frame received.
- R6: `sync_entry` is high for exactly the one cycle after the strobe that completes verification. `mf_in_sync` rises on the same edge.
- R7: While in sync, `mf_start` is high for the one cycle after each strobe of frame 0.
- R8: With `loss_chk_en` = 1, three consecutive missing words at frame 11 while in sync return the tracker to hunt. A word found in between restarts the count. With `loss_chk_en` = 0 missing words never cause loss.
- R9: While in sync, `crc_err` is sampled on every strobe. With `crc_lim_en` = 1, the strobe that brings the error count within the current window to 915 returns the tracker to hunt. With `crc_lim_en` = 0 errors have no effect on lock.
- R10: The CRC window spans 1000 submultiframe boundaries. A boundary is a strobe of frame 0 or frame 8 while in sync. At the end of the window, the error and boundary counts restart from zero. Both counts also restart whenever lock is lost.
- R11: After a synchronous reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mf_en | input | 1 | Enables the multiframe search; 0 holds the tracker idle |
| reuse_bfa | input | 1 | 1: search only on frames flagged non-FAS; 0: independent search |
| loss_chk_en | input | 1 | Enables loss of lock after three missing words |
| crc_lim_en | input | 1 | Enables the CRC-4 error limit |
| frm_start | input | 1 | One-cycle strobe per received frame |
| frm_is_fas | input | 1 | Frame carries the frame alignment signal (valid with strobe) |
| ts0_bit1 | input | 1 | First bit of timeslot 0 (valid with strobe) |
| crc_err | input | 1 | Errored submultiframe flag (valid with strobe) |
| mf_in_sync | output | 1 | Multiframe lock held |
| frame_num | output | 4 | Number of the last received frame within the multiframe |
| sync_entry | output | 1 | One-cycle pulse on gaining lock |
| mf_start | output | 1 | One-cycle pulse after frame 0 while locked |

## Verification
Clean multiframe streams with correct FAS flags show that lock is reached on the second word and that the frame count follows the true phase. The same streams with the FAS flags placed on the wrong parity lock only when the search ignores the flag, which separates the two search modes. Streams where the frame 11 bit is corrupted in two and then in three consecutive multiframes, run with the miss check on and off, separate a miss counter that restarts from one that does not. Error bursts of 914 and 915 flagged frames pin the CRC limit to the exact strobe, and a burst that straddles a window end shows that the count restarts. Random bits, random flags and sparse errors finish the run against a cycle-level reference model.

// File: rtl/mfa_pkg.sv
package mfa_pkg;

    // multiframe geometry
    localparam int MF_LEN   = 16;
    localparam int FN_W     = $clog2(MF_LEN);
    localparam int SMF_LEN  = MF_LEN / 2;

    // alignment word: bits of frames 1,3,5,7,9,11 (frame 1 is the MSB)
    localparam int WORD_LEN = 6;
    localparam logic [WORD_LEN-1:0] ALIGN_WORD = 6'b001011;
    localparam int SPAN     = 2 * WORD_LEN - 1;
    localparam logic [FN_W-1:0] WORD_END_FN = FN_W'(11);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_CHECK = 2'd2,
        ST_SYNC  = 2'd3
    } mfa_state_e;

    typedef struct packed {
        logic tick;
        logic is_fas;
        logic bit1;
        logic err;
    } frame_in_t;

    // take every second bit of the window, index 0 being the newest frame
    function automatic logic [WORD_LEN-1:0] pick_word(input logic [SPAN-1:0] win);
        logic [WORD_LEN-1:0] w;
        for (int i = 0; i < WORD_LEN; i++) begin
            w[i] = win[2*i];
        end
        return w;
    endfunction

endpackage

// File: rtl/mfa_word_detect.sv
module mfa_word_detect
    import mfa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      reuse_bfa,
    input  frame_in_t fin,
    output logic      hit
);

    logic [SPAN-2:0] hist;
    logic [SPAN-1:0] window;
    logic            word_ok;
    logic            phase_ok;

    assign window   = {hist, fin.bit1};
    assign word_ok  = (pick_word(window) == ALIGN_WORD);
    assign phase_ok = !reuse_bfa || !fin.is_fas;
    assign hit      = en && fin.tick && word_ok && phase_ok;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hist <= '0;
        end else if (fin.tick) begin
            hist <= window[SPAN-2:0];
        end
    end

    // R1
    hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (hist == '0));

endmodule

// File: rtl/mfa_crc_monitor.sv
module mfa_crc_monitor #(
    parameter int CRC_LIMIT  = 915,
    parameter int CRC_WINDOW = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tick,
    input  logic smf_bound,
    input  logic err,
    input  logic lim_en,
    output logic limit_hit
);

    localparam int EW = $clog2(CRC_LIMIT + 1);
    localparam int SW = $clog2(CRC_WINDOW);
    localparam logic [EW-1:0] ERR_MAX  = EW'(CRC_LIMIT);
    localparam logic [EW-1:0] ERR_TRIP = EW'(CRC_LIMIT - 1);
    localparam logic [SW-1:0] WIN_LAST = SW'(CRC_WINDOW - 1);

    logic [EW-1:0] err_cnt;
    logic [SW-1:0] smf_cnt;
    logic          win_end;

    assign win_end   = smf_bound && (smf_cnt == WIN_LAST);
    assign limit_hit = active && tick && err && lim_en && (err_cnt >= ERR_TRIP);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            err_cnt <= '0;
            smf_cnt <= '0;
        end else if (tick) begin
            if (win_end) begin
                err_cnt <= '0;
                smf_cnt <= '0;
            end else begin
                if (smf_bound) begin
                    smf_cnt <= smf_cnt + 1'b1;
                end
                if (err && (err_cnt != ERR_MAX)) begin
                    err_cnt <= err_cnt + 1'b1;
                end
            end
        end
    end

    // R9
    err_cap_chk: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= ERR_MAX);

    // R10
    window_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (active && tick && win_end) |=> (smf_cnt == '0 && err_cnt == '0));

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (err_cnt == '0));

endmodule

// File: rtl/mfa_align_fsm.sv
module mfa_align_fsm
    import mfa_pkg::*;
#(
    parameter int MISS_LIMIT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mf_en,
    input  logic            tick,
    input  logic            word_hit,
    input  logic            loss_chk_en,
    input  logic            crc_hit,
    output mfa_state_e      state,
    output logic [FN_W-1:0] frame_num,
    output logic            in_sync,
    output logic            sync_entry,
    output logic            mf_start,
    output logic            smf_bound
);

    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [MW-1:0]   MISS_LAST = MW'(MISS_LIMIT - 1);
    localparam logic [FN_W-1:0] SMF_FN    = FN_W'(SMF_LEN);

    logic [FN_W-1:0] inc;
    logic [MW-1:0]   miss_cnt;
    logic            at_word;

    assign inc       = frame_num + 1'b1;
    assign at_word   = (inc == WORD_END_FN);
    assign in_sync   = (state == ST_SYNC);
    assign smf_bound = in_sync && tick && ((inc == '0) || (inc == SMF_FN));

    always_ff @(posedge clk) begin
        if (rst || !mf_en) begin
            state      <= ST_IDLE;
            frame_num  <= '0;
            miss_cnt   <= '0;
            sync_entry <= 1'b0;
            mf_start   <= 1'b0;
        end else begin
            sync_entry <= 1'b0;
            mf_start   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    state <= ST_HUNT;
                end
                ST_HUNT: begin
                    if (tick) begin
                        if (word_hit) begin
                            frame_num <= WORD_END_FN;
                            state     <= ST_CHECK;
                        end else begin
                            frame_num <= inc;
                        end
                    end
                end
                ST_CHECK: begin
                    if (tick) begin
                        frame_num <= inc;
                        if (at_word) begin
                            if (word_hit) begin
                                state      <= ST_SYNC;
                                sync_entry <= 1'b1;
                                miss_cnt   <= '0;
                            end else begin
                                state <= ST_HUNT;
                            end
                        end
                    end
                end
                ST_SYNC: begin
                    if (tick) begin
                        frame_num <= inc;
                        if (crc_hit) begin
                            state <= ST_HUNT;
                        end else begin
                            mf_start <= (inc == '0);
                            if (at_word) begin
                                if (word_hit) begin
                                    miss_cnt <= '0;
                                end else if (loss_chk_en && miss_cnt == MISS_LAST) begin
                                    state <= ST_HUNT;
                                end else if (miss_cnt != MISS_LAST) begin
                                    miss_cnt <= miss_cnt + 1'b1;
                                end
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mf_en |=> (state == ST_IDLE && frame_num == '0 && !sync_entry && !mf_start));

    // R4
    entry_path_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> ($past(state) == ST_CHECK));

    // R5
    fn_step_chk: assert property (@(posedge clk) disable iff (rst)
        (in_sync && tick && mf_en) |=> (frame_num == $past(frame_num) + FN_W'(1)));

    // R6
    sync_entry_chk: assert property (@(posedge clk) disable iff (rst)
        sync_entry |-> (in_sync && frame_num == WORD_END_FN));

    // R7
    mf_start_chk: assert property (@(posedge clk) disable iff (rst)
        mf_start |-> (in_sync && frame_num == '0));

    // R8
    miss_cap_chk: assert property (@(posedge clk) disable iff (rst)
        miss_cnt <= MISS_LAST);

endmodule

// File: rtl/mfa_tracker.sv
module mfa_tracker
    import mfa_pkg::*;
#(
    parameter int MISS_LIMIT = 3,
    parameter int CRC_LIMIT  = 915,
    parameter int CRC_WINDOW = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mf_en,
    input  logic       reuse_bfa,
    input  logic       loss_chk_en,
    input  logic       crc_lim_en,
    input  logic       frm_start,
    input  logic       frm_is_fas,
    input  logic       ts0_bit1,
    input  logic       crc_err,
    output logic       mf_in_sync,
    output logic [3:0] frame_num,
    output logic       sync_entry,
    output logic       mf_start
);

    frame_in_t       fin;
    mfa_state_e      state;
    logic            word_hit;
    logic            crc_hit;
    logic            smf_bound;
    logic [FN_W-1:0] fn_int;

    assign fin = '{tick: frm_start, is_fas: frm_is_fas, bit1: ts0_bit1, err: crc_err};

    mfa_word_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .en        (mf_en),
        .reuse_bfa (reuse_bfa),
        .fin       (fin),
        .hit       (word_hit)
    );

    mfa_crc_monitor #(
        .CRC_LIMIT  (CRC_LIMIT),
        .CRC_WINDOW (CRC_WINDOW)
    ) u_crc (
        .clk       (clk),
        .rst       (rst),
        .active    (mf_in_sync),
        .tick      (fin.tick),
        .smf_bound (smf_bound),
        .err       (fin.err),
        .lim_en    (crc_lim_en),
        .limit_hit (crc_hit)
    );

    mfa_align_fsm #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mf_en       (mf_en),
        .tick        (fin.tick),
        .word_hit    (word_hit),
        .loss_chk_en (loss_chk_en),
        .crc_hit     (crc_hit),
        .state       (state),
        .frame_num   (fn_int),
        .in_sync     (mf_in_sync),
        .sync_entry  (sync_entry),
        .mf_start    (mf_start),
        .smf_bound   (smf_bound)
    );

    assign frame_num = 4'(fn_int);

    // R3
    reuse_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (mf_en && reuse_bfa && frm_start && frm_is_fas) |=> !sync_entry);

    // R9
    crc_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!crc_lim_en && mf_in_sync && frm_start && (frame_num + 4'd1 != 4'd11)) |=> (mf_in_sync || !mf_en));

endmodule

// File: tb/mfa_tracker_tb.sv
`timescale 1ns/1ps
module mfa_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       mf_en, reuse_bfa, loss_chk_en, crc_lim_en;
    logic       frm_start, frm_is_fas, ts0_bit1, crc_err;
    logic       mf_in_sync;
    logic [3:0] frame_num;
    logic       sync_entry, mf_start;

    always #2.5 clk = ~clk;

    mfa_tracker dut_i (
        .clk         (clk),
        .rst         (rst),
        .mf_en       (mf_en),
        .reuse_bfa   (reuse_bfa),
        .loss_chk_en (loss_chk_en),
        .crc_lim_en  (crc_lim_en),
        .frm_start   (frm_start),
        .frm_is_fas  (frm_is_fas),
        .ts0_bit1    (ts0_bit1),
        .crc_err     (crc_err),
        .mf_in_sync  (mf_in_sync),
        .frame_num   (frame_num),
        .sync_entry  (sync_entry),
        .mf_start    (mf_start)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_tag = "R11";
    int    tx_k   = 0;
    int    cnt_entry = 0;
    int    cnt_start = 0;

    // reference model state
    logic [9:0] m_hist;
    int m_state, m_fn, m_miss, m_err, m_smf;
    bit e_entry, e_start;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit word_match(input logic [10:0] w);
        return {w[10], w[8], w[6], w[4], w[2], w[0]} == 6'b001011;
    endfunction

    task automatic model_reset();
        m_hist = '0; m_state = 0; m_fn = 0; m_miss = 0; m_err = 0; m_smf = 0;
        e_entry = 0; e_start = 0;
    endtask

    task automatic model_cycle(input bit tk, input bit b, input bit fas, input bit err);
        logic [10:0] win;
        bit mhit, in_s, chit, bound;
        int inc;
        e_entry = 0; e_start = 0;
        if (!mf_en) begin
            model_reset();
            return;
        end
        win   = {m_hist, b};
        mhit  = tk && word_match(win) && (!reuse_bfa || !fas);
        inc   = (m_fn + 1) % 16;
        in_s  = (m_state == 3);
        chit  = in_s && tk && err && crc_lim_en && (m_err >= 914);
        bound = in_s && tk && (inc == 0 || inc == 8);
        if (!in_s) begin
            m_err = 0; m_smf = 0;
        end else if (tk) begin
            if (bound && m_smf == 999) begin
                m_smf = 0; m_err = 0;
            end else begin
                if (bound) m_smf++;
                if (err && m_err < 915) m_err++;
            end
        end
        if (tk) m_hist = win[9:0];
        case (m_state)
            0: m_state = 1;
            1: if (tk) begin
                   m_fn = inc;
                   if (mhit) begin m_fn = 11; m_state = 2; end
               end
            2: if (tk) begin
                   m_fn = inc;
                   if (inc == 11) begin
                       if (mhit) begin m_state = 3; e_entry = 1; m_miss = 0; end
                       else m_state = 1;
                   end
               end
            default: if (tk) begin
                   m_fn = inc;
                   if (chit) m_state = 1;
                   else begin
                       if (inc == 0) e_start = 1;
                       if (inc == 11) begin
                           if (mhit) m_miss = 0;
                           else if (loss_chk_en && m_miss == 2) m_state = 1;
                           else if (m_miss < 2) m_miss++;
                       end
                   end
               end
        endcase
    endtask

    // one clock: drive at negedge, advance model, sample at next negedge
    task automatic step(input bit tk, input bit b, input bit fas, input bit err);
        frm_start = tk; ts0_bit1 = b; frm_is_fas = fas; crc_err = err;
        model_cycle(tk, b, fas, err);
        @(negedge clk);
        if (sync_entry) cnt_entry++;
        if (mf_start)   cnt_start++;
        chk(cur_tag, "mf_in_sync", int'(mf_in_sync), int'(m_state == 3));
        chk(cur_tag, "frame_num",  int'(frame_num),  m_fn);
        chk(cur_tag, "sync_entry", int'(sync_entry), int'(e_entry));
        chk(cur_tag, "mf_start",   int'(mf_start),   int'(e_start));
    endtask

    // send one frame of a stream whose true phase is tx_k
    task automatic send_frame(input bit corrupt, input bit fas_one, input bit inv, input bit err);
        int k;
        bit b, fas;
        logic [5:0] word;
        word = 6'b001011;
        k    = tx_k;
        fas  = inv ? k[0] : !k[0];
        if (k[0] && k <= 11) begin
            b = word[(11 - k) / 2];
            if (corrupt && k == 11) b = !b;
        end else if (!k[0]) begin
            b = fas_one ? 1'b1 : 1'($urandom % 2);
        end else begin
            b = 1'($urandom % 2);
        end
        step(1'b1, b, fas, err);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        tx_k = (k + 1) % 16;
    endtask

    task automatic send_mfs(input int n, input bit corrupt, input bit fas_one, input bit inv);
        for (int i = 0; i < n * 16; i++) send_frame(corrupt, fas_one, inv, 1'b0);
    endtask

    task automatic align_mf();
        while (tx_k != 0) send_frame(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic restart(input int n_mf, input bit fas_one, input bit inv);
        mf_en = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        mf_en = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        send_mfs(n_mf, 1'b0, fas_one, inv);
    endtask

    initial begin
        #(5ns * 190000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; mf_en = 1'b0; reuse_bfa = 1'b1; loss_chk_en = 1'b1; crc_lim_en = 1'b1;
        frm_start = 1'b0; frm_is_fas = 1'b0; ts0_bit1 = 1'b0; crc_err = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "mf_in_sync", int'(mf_in_sync), 0);
        chk("R11", "frame_num",  int'(frame_num), 0);
        chk("R11", "sync_entry", int'(sync_entry), 0);
        chk("R11", "mf_start",   int'(mf_start), 0);
        rst = 1'b0;

        // R1: disabled tracker ignores a perfect stream
        cur_tag = "R1";
        send_mfs(3, 1'b0, 1'b0, 1'b0);
        chk("R1", "mf_in_sync while disabled", int'(mf_in_sync), 0);
        chk("R1", "frame_num while disabled", int'(frame_num), 0);
        chk("R1", "sync_entry pulses while disabled", cnt_entry, 0);

        // R4 / R6 / R2: acquisition in reuse mode
        cur_tag = "R4";
        restart(4, 1'b0, 1'b0);
        chk("R4", "locked after clean stream", int'(mf_in_sync), 1);
        chk("R6", "single sync_entry pulse", cnt_entry, 1);
        // R5: frame count equals true phase of last frame
        cur_tag = "R5";
        send_frame(1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5", "frame_num follows phase", int'(frame_num), (tx_k + 15) % 16);
        // R7: one mf_start per multiframe
        cur_tag = "R7";
        cnt_start = 0;
        send_mfs(5, 1'b0, 1'b0, 1'b0);
        chk("R7", "mf_start count over 5 multiframes", cnt_start, 5);

        // R8: two misses then a hit keep lock; three misses drop it
        cur_tag = "R8";
        align_mf();
        send_mfs(2, 1'b1, 1'b0, 1'b0);
        send_mfs(1, 1'b0, 1'b0, 1'b0);
        chk("R8", "lock after two misses and a hit", int'(mf_in_sync), 1);
        send_mfs(3, 1'b1, 1'b0, 1'b0);
        chk("R8", "lock lost after three misses", int'(mf_in_sync), 0);
        loss_chk_en = 1'b0;
        restart(3, 1'b0, 1'b0);
        align_mf();
        send_mfs(5, 1'b1, 1'b0, 1'b0);
        chk("R8", "lock kept with miss check off", int'(mf_in_sync), 1);
        loss_chk_en = 1'b1;

        // R3: wrong FAS parity blocks reuse mode, not independent mode
        cur_tag = "R3";
        reuse_bfa = 1'b1;
        cnt_entry = 0;
        restart(4, 1'b1, 1'b1);
        chk("R3", "reuse mode with wrong flags stays unlocked", int'(mf_in_sync), 0);
        chk("R3", "no sync_entry in reuse mode", cnt_entry, 0);
        reuse_bfa = 1'b0;
        restart(3, 1'b1, 1'b1);
        chk("R3", "independent mode locks despite flags", int'(mf_in_sync), 1);
        reuse_bfa = 1'b1;

        // R9: exact CRC error limit
        cur_tag = "R9";
        crc_lim_en = 1'b1;
        restart(3, 1'b0, 1'b0);
        for (int i = 0; i < 914; i++) send_frame(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9", "lock held at 914 errors", int'(mf_in_sync), 1);
        send_frame(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9", "lock lost at 915th error", int'(mf_in_sync), 0);
        crc_lim_en = 1'b0;
        restart(3, 1'b0, 1'b0);
        for (int i = 0; i < 1200; i++) send_frame(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9", "errors ignored with limit off", int'(mf_in_sync), 1);

        // R10: window end restarts the count
        cur_tag = "R10";
        crc_lim_en = 1'b1;
        restart(3, 1'b0, 1'b0);
        for (int i = 0; i < 914; i++) send_frame(1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 8100; i++) send_frame(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 914; i++) send_frame(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10", "lock held after window restart", int'(mf_in_sync), 1);

        // R2: random traffic against the model
        cur_tag = "R2";
        restart(2, 1'b0, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            bit corrupt, err;
            corrupt = ($urandom % 6) == 0;
            err     = ($urandom % 8) == 0;
            send_frame(corrupt, 1'b0, 1'b0, err);
        end
        for (int i = 0; i < 3000; i++) begin
            bit b, fas, err;
            b   = 1'($urandom % 2);
            fas = 1'($urandom % 2);
            err = ($urandom % 16) == 0;
            reuse_bfa = (i % 1000) < 500;
            step(1'b1, b, fas, err);
            step(1'b0, 1'b0, 1'b0, 1'b0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule